// File: doc/BRIEF.md
# Dual Parallel Port Interface Adapter

This block connects a microprocessor bus to two 8-bit parallel peripheral ports, A and B. Each port line can be an input or an output, chosen bit by bit through a direction register. An output register holds the levels driven on the output lines. Each side also has two control inputs, whose active transitions are caught in flag bits. The flags can raise an active-low interrupt request for that side.

The processor reaches the block through a chip select, a 2-bit register select, a read/write line, an 8-bit write bus and a registered 8-bit read bus. Every access is qualified by a strobe that lasts one clock. Each side has one control register. It sets the edge polarity of both control inputs, the interrupt enables, the mode of the second control input, and whether the port address reaches the direction register or the output register. The two flag bits in the control register are read-only. They clear as a side effect of reading the port.

The two sides return port data in different ways. A port A read always returns the pin levels. A port B read returns the output register on the output lines and the pin levels on the input lines.

Top module: `pia_core`

## Requirements
- R1: After reset, both direction registers, both output registers and both control registers are zero, so `pa_oe`/`pb_oe` and `pa_out`/`pb_out` are 0x00, both control registers read 0x00, and `irqa_n`/`irqb_n` are 1.
- R2: Register select 0 addresses port A, 1 control register A, 2 port B and 3 control register B. A port address reaches the direction register when control bit 2 is 0 and the output register when it is 1. A direction bit of 1 makes the line an output: its `*_oe` bit is 1 and `*_out` carries the output register bit.
- R3: Control bit 7 sets on an active transition of the side's first control input (`ca1`/`cb1`). Control bit 1 picks the active edge: 0 is falling, 1 is rising. A transition of the other polarity does not set it.
- R4: Control bit 6 sets on an active transition of the side's second control input (`ca2`/`cb2`), with the edge picked by control bit 4 (0 falling, 1 rising). It sets only while control bit 5 is 0. With bit 5 = 1 the input is treated as not in input mode, and its transitions are ignored.
- R5: A side's request output is low exactly when (bit 7 and bit 0) or (bit 6 and bit 3) of its control register are 1. A flag whose enable is 0 still sets, but it does not pull the request low. Each side has its own request.
- R6: A read of a side's port address while control bit 2 = 1 clears both of its flags. A read with bit 2 = 0 (a direction register read) leaves them set, and so does a control register write.
- R7: Control register writes store data bits 5:0 and ignore data bits 7:6. Control bits 5:0 read back as written.
- R8: A port A read (bit 2 = 1) returns the `pa_in` levels on every line, including lines set as outputs.
- R9: A port B read (bit 2 = 1) returns the output register bit on output lines and the `pb_in` level on input lines.
- R10: If an active transition and a flag-clearing port read fall in the same clock, the flag ends set and the request stays asserted.
- R11: Read data appears on `dout` one clock after the read strobe and holds until the next read. A direction register read returns the stored direction value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rs | input | 2 | Register select |
| rw | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | One-clock access strobe |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Registered read data to the processor |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A output enables (direction) |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B output enables (direction) |
| ca1 | input | 1 | Side A first control input |
| ca2 | input | 1 | Side A second control input |
| cb1 | input | 1 | Side B first control input |
| cb2 | input | 1 | Side B second control input |
| irqa_n | output | 1 | Side A interrupt request, active low |
| irqb_n | output | 1 | Side B interrupt request, active low |

## Verification
Flag setting and flag clearing can land in the same clock: an active control-input transition can meet a port read that would clear the flag. The bench provokes this on side A. It raises `ca1` at the same falling clock edge at which it drives the port-read strobe, with rising edges selected and the request enabled. The outcome is judged at the ports: the request must stay low, and a later control register read must still show bit 7. A second, clean port read must then clear the flag and release the request.

// File: rtl/pia_pkg.sv
`timescale 1ns/1ps
package pia_pkg;
  typedef enum logic [1:0] {
    SEL_PORT_A = 2'd0,
    SEL_CTRL_A = 2'd1,
    SEL_PORT_B = 2'd2,
    SEL_CTRL_B = 2'd3
  } pia_sel_e;

  localparam int CTRL_W      = 8;
  localparam int CFG_W       = 6;
  localparam int B_EN1       = 0;
  localparam int B_POL1      = 1;
  localparam int B_PORTSEL   = 2;
  localparam int B_EN2       = 3;
  localparam int B_POL2      = 4;
  localparam int B_C2_OUTMD  = 5;
endpackage

// File: rtl/pia_edge.sv
`timescale 1ns/1ps
module pia_edge (
  input  logic clk,
  input  logic sig,
  input  logic rising,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= sig;
  end

  always_comb begin
    if (rising) hit = sig & ~prev_q;
    else        hit = ~sig & prev_q;
  end
endmodule

// File: rtl/pia_side.sv
`timescale 1ns/1ps
module pia_side
  import pia_pkg::*;
#(
  parameter int  DW       = 8,
  parameter bit  PIN_ONLY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_port,
  input  logic              wr_ctrl,
  input  logic              rd_port,
  input  logic [DW-1:0]     wdata,
  input  logic              c1,
  input  logic              c2,
  input  logic [DW-1:0]     pin_in,
  output logic [DW-1:0]     port_out,
  output logic [DW-1:0]     port_oe,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DW-1:0]     port_rdata,
  output logic              irq_n
);
  logic [CFG_W-1:0] cfg_q, cfg_n;
  logic [DW-1:0]    ddr_q, or_q, pin_view;
  logic             f1_q, f2_q, f1_n, f2_n;
  logic             hit1, hit2, clr;

  pia_edge u_e1 (.clk(clk), .sig(c1), .rising(cfg_q[B_POL1]), .hit(hit1));
  pia_edge u_e2 (.clk(clk), .sig(c2), .rising(cfg_q[B_POL2]), .hit(hit2));

  always_comb begin
    clr   = rd_port & cfg_q[B_PORTSEL];
    f1_n  = hit1 | (f1_q & ~clr);
    f2_n  = (hit2 & ~cfg_q[B_C2_OUTMD]) | (f2_q & ~clr);
    cfg_n = wr_ctrl ? wdata[CFG_W-1:0] : cfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
      irq_n <= 1'b1;
      ddr_q <= '0;
      or_q  <= '0;
    end else begin
      cfg_q <= cfg_n;
      f1_q  <= f1_n;
      f2_q  <= f2_n;
      irq_n <= ~((f1_n & cfg_n[B_EN1]) | (f2_n & cfg_n[B_EN2]));
      if (wr_port) begin
        if (cfg_q[B_PORTSEL]) or_q  <= wdata;
        else                  ddr_q <= wdata;
      end
    end
  end

  generate
    if (PIN_ONLY) begin : g_pins
      assign pin_view = pin_in;
    end else begin : g_mixed
      assign pin_view = (or_q & ddr_q) | (pin_in & ~ddr_q);
    end
  endgenerate

  assign port_rdata = cfg_q[B_PORTSEL] ? pin_view : ddr_q;
  assign ctrl       = {f1_q, f2_q, cfg_q};
  assign port_out   = or_q;
  assign port_oe    = ddr_q;
endmodule

// File: rtl/pia_core.sv
`timescale 1ns/1ps
module pia_core
  import pia_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [1:0]    rs,
  input  logic          rw,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic          ca1,
  input  logic          ca2,
  input  logic          cb1,
  input  logic          cb2,
  output logic          irqa_n,
  output logic          irqb_n
);
  logic              acc, rd_en, wr_en;
  logic [CTRL_W-1:0] a_ctrl, b_ctrl;
  logic [DW-1:0]     a_rdata, b_rdata, rd_mux;
  pia_sel_e          sel;

  always_comb begin
    sel   = pia_sel_e'(rs);
    acc   = cs & strobe;
    rd_en = acc & rw;
    wr_en = acc & ~rw;
  end

  pia_side #(.DW(DW), .PIN_ONLY(1'b1)) u_side_a (
    .clk(clk), .rst(rst),
    .wr_port(wr_en && sel == SEL_PORT_A),
    .wr_ctrl(wr_en && sel == SEL_CTRL_A),
    .rd_port(rd_en && sel == SEL_PORT_A),
    .wdata(din), .c1(ca1), .c2(ca2), .pin_in(pa_in),
    .port_out(pa_out), .port_oe(pa_oe), .ctrl(a_ctrl),
    .port_rdata(a_rdata), .irq_n(irqa_n)
  );

  pia_side #(.DW(DW), .PIN_ONLY(1'b0)) u_side_b (
    .clk(clk), .rst(rst),
    .wr_port(wr_en && sel == SEL_PORT_B),
    .wr_ctrl(wr_en && sel == SEL_CTRL_B),
    .rd_port(rd_en && sel == SEL_PORT_B),
    .wdata(din), .c1(cb1), .c2(cb2), .pin_in(pb_in),
    .port_out(pb_out), .port_oe(pb_oe), .ctrl(b_ctrl),
    .port_rdata(b_rdata), .irq_n(irqb_n)
  );

  always_comb begin
    unique case (sel)
      SEL_PORT_A: rd_mux = a_rdata;
      SEL_CTRL_A: rd_mux = DW'(a_ctrl);
      SEL_PORT_B: rd_mux = b_rdata;
      default:    rd_mux = DW'(b_ctrl);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        dout <= '0;
    else if (rd_en) dout <= rd_mux;
  end
endmodule

// File: rtl/pia_core_chk.sv
`timescale 1ns/1ps
module pia_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       strobe,
  input logic       rw,
  input logic [1:0] rs,
  input logic       ca1,
  input logic       ca2,
  input logic       cb1,
  input logic       cb2,
  input logic [7:0] cra,
  input logic [7:0] crb,
  input logic       irqa_n,
  input logic       irqb_n
);
  // R3: flag 7 only rises after a change on the first control input
  a_r3_a_flag1_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(cra[7]) |-> ($past(ca1) != $past(ca1, 2)));
  a_r3_b_flag1_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(crb[7]) |-> ($past(cb1) != $past(cb1, 2)));
  // R4: flag 6 only rises after a change on the second control input
  a_r4_a_flag2_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(cra[6]) |-> ($past(ca2) != $past(ca2, 2)));
  a_r4_b_flag2_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(crb[6]) |-> ($past(cb2) != $past(cb2, 2)));
  // R5: with both enables low the request stays released
  a_r5_a_masked: assert property (@(posedge clk) disable iff (rst)
    (!cra[0] && !cra[3]) |-> irqa_n);
  a_r5_b_masked: assert property (@(posedge clk) disable iff (rst)
    (!crb[0] && !crb[3]) |-> irqb_n);
  // R6: a flag falls only after a port read with bit 2 set
  a_r6_a_clear_cause: assert property (@(posedge clk) disable iff (rst)
    ($fell(cra[7]) || $fell(cra[6])) |->
      $past(cs && strobe && rw && rs == 2'd0 && cra[2]));
  a_r6_b_clear_cause: assert property (@(posedge clk) disable iff (rst)
    ($fell(crb[7]) || $fell(crb[6])) |->
      $past(cs && strobe && rw && rs == 2'd2 && crb[2]));
  // R7: configuration bits change only on a control register write
  a_r7_a_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && strobe && !rw && rs == 2'd1) |-> $stable(cra[5:0]));
  a_r7_b_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cs && strobe && !rw && rs == 2'd3) |-> $stable(crb[5:0]));
endmodule

bind pia_core pia_core_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .strobe(strobe), .rw(rw), .rs(rs),
  .ca1(ca1), .ca2(ca2), .cb1(cb1), .cb2(cb2),
  .cra(a_ctrl), .crb(b_ctrl), .irqa_n(irqa_n), .irqb_n(irqb_n)
);

// File: tb/pia_core_test.sv
`timescale 1ns/1ps
module pia_core_test;
  logic       clk = 1'b0;
  logic       rst, cs, rw, strobe;
  logic [1:0] rs;
  logic [7:0] din, dout, pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic       ca1, ca2, cb1, cb2, irqa_n, irqb_n;
  int         checks = 0;
  int         errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  pia_core uut (
    .clk(clk), .rst(rst), .cs(cs), .rs(rs), .rw(rw), .strobe(strobe),
    .din(din), .dout(dout), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .ca1(ca1), .ca2(ca2), .cb1(cb1), .cb2(cb2),
    .irqa_n(irqa_n), .irqb_n(irqb_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; rs = a; din = d; strobe = 1'b1;
    @(negedge clk);
    cs = 1'b0; strobe = 1'b0; rw = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; rs = a; strobe = 1'b1;
    @(negedge clk);
    cs = 1'b0; strobe = 1'b0;
    d = dout;
  endtask

  task automatic t_reset();
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 irqs", {6'd0, irqa_n, irqb_n}, 8'h03);
    rd(2'd1, v); chk("R1 cra", v, 8'h00);
    rd(2'd3, v); chk("R1 crb", v, 8'h00);
  endtask

  task automatic t_regs();
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R7 cra bits 7:6 ignored", v, 8'h3F);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hF0);
    chk("R2 pa_oe from ddr", pa_oe, 8'hF0);
    rd(2'd0, v); chk("R11 ddr read", v, 8'hF0);
    tick(); tick();
    chk("R11 dout holds", dout, 8'hF0);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'hA5);
    chk("R2 pa_out", pa_out, 8'hA5);
    chk("R2 pa_oe unchanged", pa_oe, 8'hF0);
  endtask

  task automatic t_porta();
    pa_in = 8'h3C;
    rd(2'd0, v); chk("R8 port A reads pins", v, 8'h3C);
  endtask

  task automatic t_portb();
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hF0);
    wr(2'd3, 8'h04);
    wr(2'd2, 8'hA5);
    pb_in = 8'h3C;
    chk("R2 pb_oe", pb_oe, 8'hF0);
    chk("R2 pb_out", pb_out, 8'hA5);
    rd(2'd2, v); chk("R9 port B mixed read", v, 8'hAC);
  endtask

  task automatic t_ca1();
    wr(2'd1, 8'h04);
    ca1 = 1'b0; tick(); tick();
    chk("R5 masked flag no irq", {7'd0, irqa_n}, 8'h01);
    rd(2'd1, v); chk("R3 falling sets bit7", v, 8'h84);
    wr(2'd1, 8'h00);
    rd(2'd0, v);
    rd(2'd1, v); chk("R6 ddr read keeps flag", v, 8'h80);
    wr(2'd1, 8'h05);
    chk("R5 enable asserts irq", {7'd0, irqa_n}, 8'h00);
    rd(2'd0, v);
    chk("R6 port read releases irq", {7'd0, irqa_n}, 8'h01);
    rd(2'd1, v); chk("R6 port read clears flag", v, 8'h05);
    wr(2'd1, 8'h07);
    ca1 = 1'b1; tick(); tick();
    chk("R3 rising asserts irq", {7'd0, irqa_n}, 8'h00);
    rd(2'd1, v); chk("R3 rising sets bit7", v, 8'h87);
    rd(2'd0, v);
    ca1 = 1'b0; tick(); tick();
    rd(2'd1, v); chk("R3 falling ignored when rising chosen", v, 8'h07);
  endtask

  task automatic t_ca2();
    wr(2'd1, 8'h0C);
    ca2 = 1'b0; tick(); tick();
    chk("R4 ca2 irq", {7'd0, irqa_n}, 8'h00);
    rd(2'd1, v); chk("R4 falling sets bit6", v, 8'h4C);
    rd(2'd0, v);
    rd(2'd1, v); chk("R6 clears bit6", v, 8'h0C);
    wr(2'd1, 8'h2C);
    ca2 = 1'b1; tick(); tick();
    ca2 = 1'b0; tick(); tick();
    rd(2'd1, v); chk("R4 bit5 set ignores ca2", v, 8'h2C);
    chk("R4 bit5 set no irq", {7'd0, irqa_n}, 8'h01);
    wr(2'd1, 8'h1C);
    ca2 = 1'b1; tick(); tick();
    rd(2'd1, v); chk("R4 rising sets bit6", v, 8'h5C);
    rd(2'd0, v);
  endtask

  task automatic t_sideb();
    wr(2'd3, 8'h0D);
    cb1 = 1'b0; tick(); tick();
    chk("R5 irqb asserted", {7'd0, irqb_n}, 8'h00);
    chk("R5 irqa independent", {7'd0, irqa_n}, 8'h01);
    rd(2'd3, v); chk("R3 cb1 sets crb bit7", v, 8'h8D);
    cb2 = 1'b0; tick(); tick();
    rd(2'd3, v); chk("R4 cb2 sets crb bit6", v, 8'hCD);
    rd(2'd2, v);
    rd(2'd3, v); chk("R6 port B read clears flags", v, 8'h0D);
    chk("R6 irqb released", {7'd0, irqb_n}, 8'h01);
  endtask

  task automatic t_collide();
    wr(2'd1, 8'h07);
    rd(2'd1, v); chk("R10 setup", v, 8'h07);
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; rs = 2'd0; strobe = 1'b1; ca1 = 1'b1;
    @(negedge clk);
    cs = 1'b0; strobe = 1'b0;
    chk("R10 irq held on collision", {7'd0, irqa_n}, 8'h00);
    rd(2'd1, v); chk("R10 flag survives collision", v, 8'h87);
    rd(2'd0, v);
    rd(2'd1, v); chk("R10 later read clears", v, 8'h07);
    chk("R10 irq released", {7'd0, irqa_n}, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cs = 1'b0; rw = 1'b1; strobe = 1'b0; rs = 2'd0; din = 8'h00;
    pa_in = 8'h00; pb_in = 8'h00;
    ca1 = 1'b1; ca2 = 1'b1; cb1 = 1'b1; cb2 = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_regs();
    t_porta();
    t_portb();
    t_ca1();
    t_ca2();
    t_sideb();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule